// File: doc/BRIEF.md
# Load Value Predictor

This block guesses the data a load will return, before the cache has answered. It holds a small direct-mapped table keyed by the address of the load instruction. Each entry keeps a tag, the value that load returned last time, and a two-bit saturating confidence count. A lookup reads the table and reports the stored value. It also reports a flag that tells the pipeline whether the value is trustworthy enough to use speculatively. The normal cache access runs alongside and is not affected.

When the real data comes back, the pipeline presents it on the verify port. The block compares it with the entry. A matching value raises the entry's confidence. A differing value clears the confidence and stores the new value. A load that missed the table takes the entry over. If the entry would have been used and its value was wrong, the block pulses a squash and hands out the correct value, so that the pipeline can restart. The pipeline, the cache and the replay mechanism are outside this block.

Top module: `lvp_top`

## Requirements
- R1: While rst_ni is low and after its release, pred_use_o, pred_data_o, squash_o and fix_data_o are 0, and every entry is empty, so no lookup is used until the entries have been trained.
- R2: pred_use_o is high in the cycle after a lookup when the indexed entry is valid, its tag matches, and its confidence is 2 or 3. In that cycle pred_data_o is the stored value.
- R3: The entry index is the low 4 bits of the address and the tag is the remaining upper bits. A different tag at the same index is a miss, and a miss is never used.
- R4: A verify that misses the table fills the entry with the address tag, the actual value and confidence 0.
- R5: A verify that hits with an equal value adds 1 to the confidence, which saturates at 3 and never wraps. The stored value is kept.
- R6: A verify that hits with a different value sets the confidence to 0 and stores the actual value.
- R7: In the cycle after a verify that hits an entry with confidence 2 or 3 and a different value, squash_o is high for one cycle and fix_data_o is the actual value.
- R8: A mismatch at confidence 0 or 1 raises no squash, and neither does a verify that misses the table.
- R9: A lookup and a verify in the same cycle see the table as it was before that cycle's update.
- R10: Without lookup_valid_i, pred_use_o is low in the next cycle. Without verify_valid_i, squash_o is low in the next cycle and the table is unchanged.
- R11: pred_data_o is 0 whenever pred_use_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_pc_i | input | ADDR_W | Load instruction address to look up |
| verify_valid_i | input | 1 | Actual load data is present |
| verify_pc_i | input | ADDR_W | Load instruction address of the returning data |
| verify_data_i | input | DATA_W | Actual loaded value |
| pred_use_o | output | 1 | Prediction may be used |
| pred_data_o | output | DATA_W | Predicted value |
| squash_o | output | 1 | A used prediction was wrong: squash and restart |
| fix_data_o | output | DATA_W | Correct value that goes with squash_o |

## Verification
Both results arrive exactly one clock after their request. The prediction follows a lookup one cycle later, and the squash with its correct value follows a verify one cycle later. The table is written on the same edge that registers the squash, so a lookup in the next cycle already sees the updated entry. The reference model in the bench evaluates each rising edge against the table state from before that edge. It compares all outputs at the following falling edge. The directed checks drive on a falling edge and sample at the next falling edge, which is the edge where each registered result is due.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  typedef enum logic [1:0] {
    UPD_ALLOC   = 2'd0,
    UPD_BUMP    = 2'd1,
    UPD_REPLACE = 2'd2
  } upd_e;
endpackage

// File: rtl/lvp_table.sv
module lvp_table #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  parameter int CONF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic              rd_a_vld_o,
  output logic [TAG_W-1:0]  rd_a_tag_o,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [CONF_W-1:0] rd_a_conf_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic              rd_b_vld_o,
  output logic [TAG_W-1:0]  rd_b_tag_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic [CONF_W-1:0] rd_b_conf_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CONF_W-1:0] wr_conf_i
);
  localparam int N = 1 << IDX_W;

  logic              ent_vld  [N];
  logic [TAG_W-1:0]  ent_tag  [N];
  logic [DATA_W-1:0] ent_data [N];
  logic [CONF_W-1:0] ent_conf [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_vld[i]  <= 1'b0;
        ent_tag[i]  <= '0;
        ent_data[i] <= '0;
        ent_conf[i] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        ent_vld[i]  <= 1'b1;
        ent_tag[i]  <= wr_tag_i;
        ent_data[i] <= wr_data_i;
        ent_conf[i] <= wr_conf_i;
      end
    end
  end

  assign rd_a_vld_o  = ent_vld[rd_a_idx_i];
  assign rd_a_tag_o  = ent_tag[rd_a_idx_i];
  assign rd_a_data_o = ent_data[rd_a_idx_i];
  assign rd_a_conf_o = ent_conf[rd_a_idx_i];
  assign rd_b_vld_o  = ent_vld[rd_b_idx_i];
  assign rd_b_tag_o  = ent_tag[rd_b_idx_i];
  assign rd_b_data_o = ent_data[rd_b_idx_i];
  assign rd_b_conf_o = ent_conf[rd_b_idx_i];
endmodule

// File: rtl/lvp_match.sv
module lvp_match #(
  parameter int TAG_W    = 28,
  parameter int CONF_W   = 2,
  parameter int USE_THR  = 2
) (
  input  logic              vld_i,
  input  logic [TAG_W-1:0]  tag_ent_i,
  input  logic [TAG_W-1:0]  tag_req_i,
  input  logic [CONF_W-1:0] conf_i,
  output logic              hit_o,
  output logic              conf_ok_o
);
  assign hit_o     = vld_i && (tag_ent_i == tag_req_i);
  assign conf_ok_o = hit_o && (conf_i >= CONF_W'(USE_THR));
endmodule

// File: rtl/lvp_update.sv
module lvp_update
  import lvp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CONF_W = 2
) (
  input  logic              hit_i,
  input  logic              conf_ok_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic [CONF_W-1:0] ent_conf_i,
  input  logic [DATA_W-1:0] act_data_i,
  output upd_e              action_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CONF_W-1:0] wr_conf_o,
  output logic              squash_o
);
  logic same;
  assign same = (ent_data_i == act_data_i);

  always_comb begin
    if (!hit_i)     action_o = UPD_ALLOC;
    else if (same)  action_o = UPD_BUMP;
    else            action_o = UPD_REPLACE;
  end

  always_comb begin
    wr_data_o = act_data_i;
    wr_conf_o = '0;
    unique case (action_o)
      UPD_BUMP: begin
        wr_data_o = ent_data_i;
        wr_conf_o = (ent_conf_i == '1) ? ent_conf_i : ent_conf_i + 1'b1;
      end
      default: ;
    endcase
  end

  // only a prediction that would have been used can be wrong enough to squash
  assign squash_o = conf_ok_i && (action_o == UPD_REPLACE);
endmodule

// File: rtl/lvp_top.sv
module lvp_top
  import lvp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int CONF_W  = 2,
  parameter int USE_THR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_pc_i,
  input  logic              verify_valid_i,
  input  logic [ADDR_W-1:0] verify_pc_i,
  input  logic [DATA_W-1:0] verify_data_i,
  output logic              pred_use_o,
  output logic [DATA_W-1:0] pred_data_o,
  output logic              squash_o,
  output logic [DATA_W-1:0] fix_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, vf_idx;
  logic [TAG_W-1:0]  lk_tag, vf_tag;
  logic              lk_vld, vf_vld;
  logic [TAG_W-1:0]  lk_ent_tag, vf_ent_tag;
  logic [DATA_W-1:0] lk_ent_data, vf_ent_data;
  logic [CONF_W-1:0] lk_ent_conf, vf_ent_conf;
  logic              lk_hit, lk_ok, vf_hit, vf_ok;
  upd_e              vf_action;
  logic [DATA_W-1:0] wr_data;
  logic [CONF_W-1:0] wr_conf;
  logic              squash_d;

  assign lk_idx = lookup_pc_i[IDX_W-1:0];
  assign lk_tag = lookup_pc_i[ADDR_W-1:IDX_W];
  assign vf_idx = verify_pc_i[IDX_W-1:0];
  assign vf_tag = verify_pc_i[ADDR_W-1:IDX_W];

  lvp_table #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CONF_W(CONF_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_a_idx_i  (lk_idx),
    .rd_a_vld_o  (lk_vld),
    .rd_a_tag_o  (lk_ent_tag),
    .rd_a_data_o (lk_ent_data),
    .rd_a_conf_o (lk_ent_conf),
    .rd_b_idx_i  (vf_idx),
    .rd_b_vld_o  (vf_vld),
    .rd_b_tag_o  (vf_ent_tag),
    .rd_b_data_o (vf_ent_data),
    .rd_b_conf_o (vf_ent_conf),
    .wr_en_i     (verify_valid_i),
    .wr_idx_i    (vf_idx),
    .wr_tag_i    (vf_tag),
    .wr_data_i   (wr_data),
    .wr_conf_i   (wr_conf)
  );

  lvp_match #(.TAG_W(TAG_W), .CONF_W(CONF_W), .USE_THR(USE_THR)) u_lk_match (
    .vld_i(lk_vld), .tag_ent_i(lk_ent_tag), .tag_req_i(lk_tag),
    .conf_i(lk_ent_conf), .hit_o(lk_hit), .conf_ok_o(lk_ok)
  );

  lvp_match #(.TAG_W(TAG_W), .CONF_W(CONF_W), .USE_THR(USE_THR)) u_vf_match (
    .vld_i(vf_vld), .tag_ent_i(vf_ent_tag), .tag_req_i(vf_tag),
    .conf_i(vf_ent_conf), .hit_o(vf_hit), .conf_ok_o(vf_ok)
  );

  lvp_update #(.DATA_W(DATA_W), .CONF_W(CONF_W)) u_update (
    .hit_i      (vf_hit),
    .conf_ok_i  (vf_ok),
    .ent_data_i (vf_ent_data),
    .ent_conf_i (vf_ent_conf),
    .act_data_i (verify_data_i),
    .action_o   (vf_action),
    .wr_data_o  (wr_data),
    .wr_conf_o  (wr_conf),
    .squash_o   (squash_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_use_o  <= 1'b0;
      pred_data_o <= '0;
      squash_o    <= 1'b0;
      fix_data_o  <= '0;
    end else begin
      pred_use_o  <= lookup_valid_i && lk_ok;
      pred_data_o <= (lookup_valid_i && lk_ok) ? lk_ent_data : '0;
      squash_o    <= verify_valid_i && squash_d;
      if (verify_valid_i && squash_d) fix_data_o <= verify_data_i;
    end
  end
endmodule

// File: rtl/lvp_checker.sv
module lvp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_valid_i,
  input logic              verify_valid_i,
  input logic [DATA_W-1:0] verify_data_i,
  input logic              vf_hit,
  input logic              pred_use_o,
  input logic [DATA_W-1:0] pred_data_o,
  input logic              squash_o,
  input logic [DATA_W-1:0] fix_data_o
);
  p_no_lookup_no_use_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !pred_use_o);

  p_no_verify_no_squash_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verify_valid_i |=> !squash_o);

  p_data_zero_unused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_use_o |-> (pred_data_o == '0));

  p_fix_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verify_valid_i && vf_hit) |=> (!squash_o || (fix_data_o == $past(verify_data_i))));

  p_miss_no_squash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verify_valid_i && !vf_hit) |=> !squash_o);

  p_squash_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o && !verify_valid_i) |=> !squash_o);
endmodule

bind lvp_top lvp_checker #(.DATA_W(DATA_W)) u_lvp_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .verify_valid_i (verify_valid_i),
  .verify_data_i  (verify_data_i),
  .vf_hit         (vf_hit),
  .pred_use_o     (pred_use_o),
  .pred_data_o    (pred_data_o),
  .squash_o       (squash_o),
  .fix_data_o     (fix_data_o)
);

// File: tb/lvp_top_tb_top.sv
module lvp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_v = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        vf_v = 1'b0;
  logic [31:0] vf_pc = '0;
  logic [31:0] vf_d = '0;
  logic        use_o;
  logic [31:0] pdata_o;
  logic        sq_o;
  logic [31:0] fix_o;

  int total = 0;
  int bad = 0;
  string ph = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvp_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lk_v), .lookup_pc_i(lk_pc),
    .verify_valid_i(vf_v), .verify_pc_i(vf_pc), .verify_data_i(vf_d),
    .pred_use_o(use_o), .pred_data_o(pdata_o),
    .squash_o(sq_o), .fix_data_o(fix_o)
  );

  // behavioural reference: associative state per index
  bit          m_vld [N];
  logic [27:0] m_tag [N];
  logic [31:0] m_val [N];
  int          m_conf[N];
  logic        e_use, e_sq;
  logic [31:0] e_data, e_fix;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vld[i] = 0; m_tag[i] = '0; m_val[i] = '0; m_conf[i] = 0;
      end
      e_use = 0; e_data = '0; e_sq = 0; e_fix = '0;
    end else begin
      int li, vi;
      li = int'(lk_pc[3:0]);
      vi = int'(vf_pc[3:0]);
      e_use = lk_v && m_vld[li] && m_tag[li] == lk_pc[31:4] && m_conf[li] >= 2;
      e_data = e_use ? m_val[li] : '0;
      e_sq = 0;
      if (vf_v) begin
        if (m_vld[vi] && m_tag[vi] == vf_pc[31:4]) begin
          if (m_val[vi] == vf_d) begin
            if (m_conf[vi] < 3) m_conf[vi]++;
          end else begin
            if (m_conf[vi] >= 2) begin e_sq = 1; e_fix = vf_d; end
            m_conf[vi] = 0; m_val[vi] = vf_d;
          end
        end else begin
          m_vld[vi] = 1; m_tag[vi] = vf_pc[31:4]; m_val[vi] = vf_d; m_conf[vi] = 0;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({ph, " use"}, 32'(use_o), 32'(e_use));
      chk({ph, " data"}, pdata_o, e_data);
      chk({ph, " squash"}, 32'(sq_o), 32'(e_sq));
      if (e_sq) chk({ph, " fix"}, fix_o, e_fix);
    end
  end

  task automatic lookup(logic [31:0] pc, bit exp_use, logic [31:0] exp_d, string req);
    @(negedge clk); lk_v = 1; lk_pc = pc;
    @(negedge clk); lk_v = 0;
    chk({req, " directed use"}, 32'(use_o), 32'(exp_use));
    chk({req, " directed data"}, pdata_o, exp_d);
  endtask

  task automatic verify(logic [31:0] pc, logic [31:0] d, bit exp_sq, string req);
    @(negedge clk); vf_v = 1; vf_pc = pc; vf_d = d;
    @(negedge clk); vf_v = 0;
    chk({req, " directed squash"}, 32'(sq_o), 32'(exp_sq));
    if (exp_sq) chk({req, " directed fix"}, fix_o, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset use", 32'(use_o), 0);
    chk("R1 reset squash", 32'(sq_o), 0);
    rst_n = 1;
    ph = "R1";
    lookup(32'h100, 0, 0, "R1");
    ph = "R4";
    verify(32'h100, 32'h11, 0, "R4");
    lookup(32'h100, 0, 0, "R4");
    ph = "R5";
    verify(32'h100, 32'h11, 0, "R5");
    lookup(32'h100, 0, 0, "R5");
    verify(32'h100, 32'h11, 0, "R5");
    lookup(32'h100, 1, 32'h11, "R2");
    verify(32'h100, 32'h11, 0, "R5");
    verify(32'h100, 32'h11, 0, "R5");
    verify(32'h100, 32'h11, 0, "R5");
    lookup(32'h100, 1, 32'h11, "R5");
    ph = "R7";
    verify(32'h100, 32'h22, 1, "R7");
    ph = "R6";
    lookup(32'h100, 0, 0, "R6");
    ph = "R8";
    verify(32'h100, 32'h33, 0, "R8");
    verify(32'h200, 32'h44, 0, "R8");
    ph = "R3";
    verify(32'h200, 32'h44, 0, "R3");
    verify(32'h200, 32'h44, 0, "R3");
    lookup(32'h200, 1, 32'h44, "R3");
    lookup(32'h100, 0, 0, "R3");
    lookup(32'h204, 0, 0, "R3");
    ph = "R9";
    @(negedge clk); lk_v = 1; lk_pc = 32'h200; vf_v = 1; vf_pc = 32'h200; vf_d = 32'h55;
    @(negedge clk); lk_v = 0; vf_v = 0;
    chk("R9 old value used", pdata_o, 32'h44);
    chk("R9 squash", 32'(sq_o), 1);
    lookup(32'h200, 0, 0, "R9");
    ph = "R10";
    repeat (3) @(negedge clk);
    chk("R10 idle use", 32'(use_o), 0);
    chk("R11 idle data", pdata_o, 0);
    ph = "R2 random";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      lk_v = 1'($urandom_range(0, 1));
      lk_pc = (32'($urandom_range(0, 2)) << 8) | 32'($urandom_range(0, 2) * 4);
      vf_v = 1'($urandom_range(0, 1));
      vf_pc = (32'($urandom_range(0, 2)) << 8) | 32'($urandom_range(0, 2) * 4);
      vf_d = ($urandom_range(0, 5) == 0) ? 32'h9 : 32'h7;
    end
    @(negedge clk); lk_v = 0; vf_v = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule